// File: doc/BRIEF.md
# Clock Generator Mode and Strap Controller

This block sets the operating mode of a clock generator's output groups. At power-on it reads two configuration straps from pads that are later driven as reference-clock outputs. One strap turns on spread spectrum (a 0.5% down-spread on the CPU and PCI groups) when it reads low. The other picks 24 MHz (high) or 48 MHz (low) for the shared USB clock pin. Once the straps are latched, the block gives the pads back to the reference output path. The latched values hold until the next reset.

Two asynchronous select pins, a tri-state-not pin and a speed select, are synchronised and decoded into one of four modes: high-impedance, test, active low-speed (66.6 MHz CPU) and active high-speed (100 MHz CPU). PCI stays at 33.3 MHz in both active modes. In test mode the block's clock is the test clock applied on the oscillator input. The CPU group then gets that clock divided by 2, the PCI groups get it divided by 6, and the reference group is switched to the test clock itself. The PLL, the spread modulator and the pads are outside the block. They see only the enable, output-enable and select signals it produces. No data flows through the block, so every pin is a plain level with no handshake.

Top module: `clkmode_ctrl`

## Requirements
- R1: While reset is asserted, every output is 0: all output-enables and group enables, spread_en_o, freq_hi_o, sel24_o, ref_tclk_sel_o, strap_done_o, strap_pin_oe_o and both test clocks.
- R2: strap_done_o rises on the 4th rising edge after reset is released (SETTLE_CYCLES+1 with the default of 3), and stays low before that edge.
- R3: spread_en_o is 1 only when the latched spread strap read 0 and the current mode is active (tristate_n_i=1). It is 0 in the test and high-impedance modes.
- R4: sel24_o equals the latched value of strap_sel48_n_i. A value of 1 selects 24 MHz and 0 selects 48 MHz.
- R5: After strap_done_o is 1, changes on either strap pin have no effect on spread_en_o or sel24_o until the next reset.
- R6: strap_pin_oe_o is 1 exactly when strap_done_o is 1 and ref_oe_o is 1. The strap pads then drive as ordinary reference outputs.
- R7: Code {tristate_n_i,speed_sel_i}=00 (high-impedance) sets all four group output-enables to 0, all group enables to 0, freq_hi_o to 0 and ref_tclk_sel_o to 0.
- R8: Codes 10 and 11 (active) set all output-enables and group enables to 1, freq_hi_o to speed_sel_i (1 = 100 MHz CPU, 0 = 66.6 MHz) and ref_tclk_sel_o to 0.
- R9: Code 01 (test) sets all output-enables to 1, all group enables to 0, freq_hi_o to 0 and ref_tclk_sel_o to 1.
- R10: In test mode tst_cpu_clk_o toggles on every clock edge (divide by 2). tst_pci_clk_o is high for 3 cycles and low for 3 cycles (divide by 6). Both have 50% duty.
- R11: Outside test mode both test clocks are low. They return low by the 4th rising edge after the select pins leave the test code.
- R12: A change on the select pins reaches the mode outputs on the 3rd rising edge after it: two synchroniser stages and one output register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock (the test clock in test mode) |
| rst_ni | input | 1 | Asynchronous active-low reset |
| strap_spread_n_i | input | 1 | Spread strap pad input, low enables spread |
| strap_sel48_n_i | input | 1 | USB frequency strap pad input, high selects 24 MHz |
| tristate_n_i | input | 1 | Mode select, low selects high-impedance or test |
| speed_sel_i | input | 1 | Speed select |
| strap_done_o | output | 1 | Straps latched |
| strap_pin_oe_o | output | 1 | Strap pads drive as reference outputs |
| cpu_oe_o | output | 1 | CPU group output-enable |
| pci_oe_o | output | 1 | PCI group output-enable |
| pcif_oe_o | output | 1 | Free-running PCI output-enable |
| ref_oe_o | output | 1 | Reference group output-enable |
| cpu_en_o | output | 1 | CPU group fed by the PLL |
| pci_en_o | output | 1 | PCI group fed by the PLL |
| pcif_en_o | output | 1 | Free-running PCI fed by the PLL |
| ref_en_o | output | 1 | Reference group fed by the oscillator |
| spread_en_o | output | 1 | Spread modulation enable |
| freq_hi_o | output | 1 | CPU at 100 MHz when 1 |
| sel24_o | output | 1 | USB pin at 24 MHz when 1 |
| ref_tclk_sel_o | output | 1 | Reference group switched to the test clock |
| tst_cpu_clk_o | output | 1 | Test clock divided by 2 |
| tst_pci_clk_o | output | 1 | Test clock divided by 6 |

## Verification
A select change is driven at a falling edge. The mode outputs are sampled at the falling edge after the 2nd rising edge, where they must still show the old mode, and again after the 3rd, where they must show the new mode. Strap completion is checked at the falling edges after the 3rd and the 4th rising edge following reset release. The test clocks are given ten cycles to start and are then sampled at 24 consecutive falling edges, each sample compared against the one a half-period earlier. The check that they return low waits five rising edges after the test code is left, one more than the four the path needs.

// File: rtl/clkmode_pkg.sv
package clkmode_pkg;
  typedef enum logic [1:0] {
    MODE_HIZ  = 2'b00,
    MODE_TEST = 2'b01,
    MODE_LOW  = 2'b10,
    MODE_HIGH = 2'b11
  } mode_e;

  localparam int NUM_GRP  = 4;
  localparam int GRP_CPU  = 0;
  localparam int GRP_PCI  = 1;
  localparam int GRP_PCIF = 2;
  localparam int GRP_REF  = 3;

  typedef struct packed {
    logic [NUM_GRP-1:0] oe;
    logic [NUM_GRP-1:0] en;
    logic               freq_hi;
    logic               tclk_sel;
  } mode_ctrl_t;
endpackage

// File: rtl/clkmode_sync.sv
module clkmode_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[s] <= '0;
      else if (s == 0) stage_q[s] <= d_i;
      else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/clkmode_strap.sv
module clkmode_strap #(
  parameter int WIDTH         = 2,
  parameter int SETTLE_CYCLES = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] pins_sync_i,
  output logic [WIDTH-1:0] straps_o,
  output logic             done_o
);
  localparam int CW = $clog2(SETTLE_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(SETTLE_CYCLES);

  logic [CW-1:0]    cnt_q;
  logic [WIDTH-1:0] straps_q;
  logic             done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      straps_q <= '0;
      done_q   <= 1'b0;
    end else if (!done_q) begin
      if (cnt_q == LAST) begin
        straps_q <= pins_sync_i;
        done_q   <= 1'b1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign straps_o = straps_q;
  assign done_o   = done_q;

  // R5
  strap_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> (done_q && $stable(straps_q)));
  // R2
  strap_early_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q != LAST) |=> !done_q);
endmodule

// File: rtl/clkmode_decode.sv
module clkmode_decode
  import clkmode_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] code_i,
  output mode_ctrl_t ctrl_o,
  output logic       active_o
);
  mode_ctrl_t ctrl_d, ctrl_q;
  logic       active_q;
  mode_e      mode;

  assign mode = mode_e'(code_i);

  always_comb begin
    ctrl_d = '0;
    case (mode)
      MODE_TEST: begin
        ctrl_d.oe       = '1;
        ctrl_d.tclk_sel = 1'b1;
      end
      MODE_LOW: begin
        ctrl_d.oe = '1;
        ctrl_d.en = '1;
      end
      MODE_HIGH: begin
        ctrl_d.oe      = '1;
        ctrl_d.en      = '1;
        ctrl_d.freq_hi = 1'b1;
      end
      default: ctrl_d = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q   <= '0;
      active_q <= 1'b0;
    end else begin
      ctrl_q   <= ctrl_d;
      active_q <= code_i[1];
    end
  end

  assign ctrl_o   = ctrl_q;
  assign active_o = active_q;

  // R8
  freq_sel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({ctrl_q.freq_hi, ctrl_q.tclk_sel}));
  // R12
  decode_lat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (code_i == 2'b00) |=> (ctrl_q.oe == '0));
endmodule

// File: rtl/clkmode_div.sv
module clkmode_div #(
  parameter int DIV = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic clk_o
);
  localparam int HALF = DIV / 2;
  localparam int CW   = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [CW-1:0] WRAP = CW'(HALF - 1);

  logic [CW-1:0] cnt_q;
  logic          out_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      out_q <= 1'b0;
    end else if (!en_i) begin
      cnt_q <= '0;
      out_q <= 1'b0;
    end else if (cnt_q == WRAP) begin
      cnt_q <= '0;
      out_q <= ~out_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign clk_o = out_q;

  // R11
  div_idle_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !out_q);

  if (HALF > 1) begin : g_wide
    // R10
    div_high_run_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (en_i && $rose(out_q)) |=> out_q);
  end else begin : g_fast
    // R10
    div_toggle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      out_q |=> !out_q);
  end
endmodule

// File: rtl/clkmode_ctrl.sv
module clkmode_ctrl
  import clkmode_pkg::*;
#(
  parameter int SETTLE_CYCLES = 3,
  parameter int SYNC_STAGES   = 2,
  parameter int CPU_TDIV      = 2,
  parameter int PCI_TDIV      = 6
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic strap_spread_n_i,
  input  logic strap_sel48_n_i,
  input  logic tristate_n_i,
  input  logic speed_sel_i,
  output logic strap_done_o,
  output logic strap_pin_oe_o,
  output logic cpu_oe_o,
  output logic pci_oe_o,
  output logic pcif_oe_o,
  output logic ref_oe_o,
  output logic cpu_en_o,
  output logic pci_en_o,
  output logic pcif_en_o,
  output logic ref_en_o,
  output logic spread_en_o,
  output logic freq_hi_o,
  output logic sel24_o,
  output logic ref_tclk_sel_o,
  output logic tst_cpu_clk_o,
  output logic tst_pci_clk_o
);
  localparam int NDIV = 2;
  localparam int DIVS [NDIV] = '{CPU_TDIV, PCI_TDIV};

  logic [1:0]      strap_sync, straps, code_sync;
  logic            done, active;
  mode_ctrl_t      ctrl;
  logic [NDIV-1:0] tclk;

  clkmode_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_strap_sync (
    .clk_i (clk_i), .rst_ni (rst_ni),
    .d_i   ({strap_sel48_n_i, strap_spread_n_i}),
    .q_o   (strap_sync)
  );

  clkmode_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_code_sync (
    .clk_i (clk_i), .rst_ni (rst_ni),
    .d_i   ({tristate_n_i, speed_sel_i}),
    .q_o   (code_sync)
  );

  clkmode_strap #(.WIDTH(2), .SETTLE_CYCLES(SETTLE_CYCLES)) u_strap (
    .clk_i (clk_i), .rst_ni (rst_ni),
    .pins_sync_i (strap_sync), .straps_o (straps), .done_o (done)
  );

  clkmode_decode u_decode (
    .clk_i (clk_i), .rst_ni (rst_ni),
    .code_i (code_sync), .ctrl_o (ctrl), .active_o (active)
  );

  for (genvar d = 0; d < NDIV; d++) begin : g_tdiv
    clkmode_div #(.DIV(DIVS[d])) u_div (
      .clk_i (clk_i), .rst_ni (rst_ni),
      .en_i  (ctrl.tclk_sel), .clk_o (tclk[d])
    );
  end

  assign strap_done_o   = done;
  assign strap_pin_oe_o = done & ctrl.oe[GRP_REF];
  assign cpu_oe_o       = ctrl.oe[GRP_CPU];
  assign pci_oe_o       = ctrl.oe[GRP_PCI];
  assign pcif_oe_o      = ctrl.oe[GRP_PCIF];
  assign ref_oe_o       = ctrl.oe[GRP_REF];
  assign cpu_en_o       = ctrl.en[GRP_CPU];
  assign pci_en_o       = ctrl.en[GRP_PCI];
  assign pcif_en_o      = ctrl.en[GRP_PCIF];
  assign ref_en_o       = ctrl.en[GRP_REF];
  assign spread_en_o    = ~straps[0] & done & active;
  assign sel24_o        = straps[1];
  assign freq_hi_o      = ctrl.freq_hi;
  assign ref_tclk_sel_o = ctrl.tclk_sel;
  assign tst_cpu_clk_o  = tclk[0];
  assign tst_pci_clk_o  = tclk[1];

  // R3
  spread_active_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    spread_en_o |-> (cpu_en_o && pci_en_o && !ref_tclk_sel_o));
  // R9
  test_route_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_tclk_sel_o |-> (!cpu_en_o && cpu_oe_o && ref_oe_o));
  // R6
  pin_oe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strap_pin_oe_o |-> (strap_done_o && ref_oe_o));
endmodule

// File: tb/test_clkmode_ctrl.sv
module test_clkmode_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sp_n = 1'b1, s48_n = 1'b1, ts_n = 1'b0, sel = 1'b0;
  logic strap_done, pin_oe, cpu_oe, pci_oe, pcif_oe, ref_oe;
  logic cpu_en, pci_en, pcif_en, ref_en, spread_en, freq_hi, sel24, tclk_sel;
  logic tcpu, tpci;
  int   checks = 0, fails = 0;
  bit   done_flag = 1'b0;

  always #2 clk = ~clk;

  clkmode_ctrl i_clkmode_ctrl (
    .clk_i (clk), .rst_ni (rst_n),
    .strap_spread_n_i (sp_n), .strap_sel48_n_i (s48_n),
    .tristate_n_i (ts_n), .speed_sel_i (sel),
    .strap_done_o (strap_done), .strap_pin_oe_o (pin_oe),
    .cpu_oe_o (cpu_oe), .pci_oe_o (pci_oe), .pcif_oe_o (pcif_oe), .ref_oe_o (ref_oe),
    .cpu_en_o (cpu_en), .pci_en_o (pci_en), .pcif_en_o (pcif_en), .ref_en_o (ref_en),
    .spread_en_o (spread_en), .freq_hi_o (freq_hi), .sel24_o (sel24),
    .ref_tclk_sel_o (tclk_sel), .tst_cpu_clk_o (tcpu), .tst_pci_clk_o (tpci)
  );

  // {oe cpu,pci,pcif,ref, en cpu,pci,pcif,ref, freq_hi, tclk_sel}
  function automatic logic [9:0] exp_ctrl(input logic [1:0] code);
    case (code)
      2'b01:   return {4'hF, 4'h0, 1'b0, 1'b1};
      2'b10:   return {4'hF, 4'hF, 1'b0, 1'b0};
      2'b11:   return {4'hF, 4'hF, 1'b1, 1'b0};
      default: return 10'd0;
    endcase
  endfunction

  function automatic logic [9:0] act_ctrl();
    return {cpu_oe, pci_oe, pcif_oe, ref_oe, cpu_en, pci_en, pcif_en, ref_en, freq_hi, tclk_sel};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset(input logic sp, input logic s48, input logic [1:0] code);
    @(negedge clk);
    rst_n = 1'b0; sp_n = sp; s48_n = s48; {ts_n, sel} = code;
    cyc(2);
    // R1 reset state
    chk("R1", {act_ctrl(), strap_done, pin_oe, spread_en, sel24, tcpu, tpci}, 32'd0);
    rst_n = 1'b1;
    cyc(3);
    // R2 not yet latched
    chk("R2", {strap_done, pin_oe}, 32'd0);
    cyc(1);
    chk("R2", strap_done, 1);
    // R4, R3, R6
    chk("R4", sel24, s48);
    chk("R3", spread_en, (!sp && code[1]));
    chk("R6", pin_oe, (code != 2'b00));
    // R5 strap pins ignored now
    sp_n = ~sp; s48_n = ~s48;
    cyc(6);
    chk("R5", {spread_en, sel24}, {(!sp && code[1]), s48});
  endtask

  task automatic mode_step(input logic [1:0] code, input logic sp, input logic [1:0] prev);
    @(negedge clk);
    {ts_n, sel} = code;
    cyc(2);
    // R12 old mode still present after two edges
    chk("R12", act_ctrl(), exp_ctrl(prev));
    cyc(1);
    if (code == 2'b00)      chk("R7", act_ctrl(), exp_ctrl(code));
    else if (code == 2'b01) chk("R9", act_ctrl(), exp_ctrl(code));
    else                    chk("R8", act_ctrl(), exp_ctrl(code));
    chk("R3", spread_en, (!sp && code[1]));
    chk("R6", pin_oe, (code != 2'b00));
    if (code != 2'b01 && prev != 2'b01) chk("R11", {tcpu, tpci}, 0);
  endtask

  task automatic test_clocks(input logic [1:0] prev);
    logic [23:0] sc, sp6;
    @(negedge clk);
    {ts_n, sel} = 2'b01;
    cyc(10);
    for (int i = 0; i < 24; i++) begin
      sc[i] = tcpu; sp6[i] = tpci;
      cyc(1);
    end
    chk("R10", $countones(sc), 12);
    chk("R10", $countones(sp6), 12);
    for (int i = 1; i < 24; i++) chk("R10", sc[i], !sc[i-1]);
    for (int i = 3; i < 24; i++) chk("R10", sp6[i], !sp6[i-3]);
    {ts_n, sel} = prev;
    cyc(5);
    chk("R11", {tcpu, tpci}, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done_flag) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [1:0] prev, code;
    logic sp, s48;
    int unused_seed;
    unused_seed = $urandom(32'h5EED_0042);
    for (int r = 0; r < 6; r++) begin
      sp   = (r < 2) ? r[0] : 1'($urandom);
      s48  = (r < 2) ? !r[0] : 1'($urandom);
      prev = (r < 4) ? 2'(r) : 2'($urandom);
      do_reset(sp, s48, prev);
      for (int k = 0; k < 12; k++) begin
        code = 2'($urandom);
        mode_step(code, sp, prev);
        prev = code;
      end
      if (prev == 2'b01) begin
        mode_step(2'b10, sp, prev);
        prev = 2'b10;
      end
      test_clocks(prev);
    end
    done_flag = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule